// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

The block pairs two compare channels with one shared free-running 16-bit up-counter. Each channel holds a compare value. When the counter equals that value on a counting cycle and the channel is running, the channel's output latch inverts and its interrupt flag is set. Channel 1 can be linked so that it also inverts on a channel 0 match. With the counter set to clear on a channel 0 match, this gives a fixed period with a programmable duty point, which is a simple PWM.

The counter counts either every clock cycle or on rising edges of an external clock input. It sets an overflow flag when it wraps, and software can clear it at any time. Each output pin shows either the channel latch or a general-purpose port value, chosen per pin. Software reaches all state through a small register port. Writes are synchronous and reads are combinational.

Register map (3-bit address):
- 0, control: bit 0/1 run ch0/ch1, bit 2/3 interrupt enable ch0/ch1, bit 4/5 interrupt flag ch0/ch1, bit 6/7 latch level ch0/ch1, bit 8 link.
- 1, compare value ch0.
- 2, compare value ch1.
- 3, timer control: bit 0 overflow flag, bit 1 clear strobe (reads 0), bit 2 clear-on-match, bit 3 external clock select.
- 4, counter value (read-only).

Top module: `ocu_pair`

## Requirements
- R1: With the internal clock selected (timer control bit 3 = 0), the counter rises by one every cycle. It wraps from 0xFFFF to 0, and on that wrap it sets the overflow flag (timer control bit 0).
- R2: Writing timer control with bit 0 = 0 clears the overflow flag, and bit 0 = 1 leaves it unchanged. Writing bit 1 = 1 resets the counter to 0, and bit 1 = 0 leaves it counting.
- R3: With clear-on-match set (timer control bit 2 = 1), the counter returns to 0 on the count after it equals the channel 0 compare value, so the period is compare0 + 1 counts.
- R4: A running channel (control bit 0/1 = 1) inverts its latch on each count where counter equals its compare value. A stopped channel's latch never changes on a match.
- R5: With link = 0 (control bit 8), latch 1 inverts only on a channel 1 match. With link = 1, latch 1 also inverts on a channel 0 match, provided both channels run.
- R6: A channel match sets that channel's interrupt flag (control bit 4/5). Writing 0 to the flag bit clears it, and writing 1 leaves it unchanged.
- R7: irq is 1 exactly when, for at least one channel, the flag and its enable (control bit 2/3) are both 1.
- R8: A control write loads latch levels from bits 6/7 only for channels that are stopped at the time of the write. For a running channel those bits are ignored. Reads of bits 6/7 return the latch levels.
- R9: pin_out[i] equals latch i when port_sel[i] = 1, and gpio_dout[i] when port_sel[i] = 0.
- R10: With timer control bit 3 = 1, the counter advances once per rising edge of ext_clk, after a two-flop synchronizer and an edge detector. It does not advance on other cycles.
- R11: After reset, all registers, flags, latches and the counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ext_clk | input | 1 | External count clock, asynchronous |
| port_sel | input | 2 | Per-pin select: 1 = compare latch, 0 = port data |
| gpio_dout | input | 2 | General-purpose port data |
| pin_out | output | 2 | Output pins |
| irq | output | 1 | Shared interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, and a read is combinational. The bench therefore checks each write's effect at the falling edge after that write. On the internal clock, a latch toggle appears right after the edge on which the counter equals the compare value. The bench measures toggle-to-toggle intervals in whole cycles and compares them with compare0 + 1 or with the linked split (compare0 − compare1, compare1 + 1). In external clock mode, the count trails an ext_clk rising edge by three cycles. The bench holds each ext_clk level for five cycles before reading the count.

// File: rtl/ocu_pkg.sv
// Package: register addresses and control-register bit positions shared by
// the output compare unit and its checker.
package ocu_pkg;
    localparam int ADDR_W = 3;
    localparam int NCH    = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP1 = 3'd2;
    localparam logic [ADDR_W-1:0] A_TCTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_TCNT = 3'd4;

    // control register fields (lowest bit of each per-channel pair)
    localparam int B_RUN  = 0;
    localparam int B_IEN  = 2;
    localparam int B_FLAG = 4;
    localparam int B_LVL  = 6;
    localparam int B_LINK = 8;

    // timer control fields
    localparam int T_OVF  = 0;
    localparam int T_CLR  = 1;
    localparam int T_MODE = 2;
    localparam int T_EXT  = 3;
endpackage

// File: rtl/ocu_timer.sv
// Module: shared free-running up-counter.
// Counts every cycle, or on synchronized rising edges of ext_clk when
// ext_sel is set. A software clear has priority over the clear-on-match,
// which has priority over counting. The match test uses the count before
// its increment. Assumes ext_clk is asynchronous and slower than clk / 2.
module ocu_timer #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             ext_clk,
    input  logic             sw_clr,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] cmp0,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tick,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SYNC_N:0] ext_sh;
    logic            ext_rise;
    logic            hit_clr;

    // synchronizer chain plus one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[SYNC_N-1:0], ext_clk};
    end

    assign ext_rise = ext_sh[SYNC_N-1] & ~ext_sh[SYNC_N];
    assign tick     = ext_sel ? ext_rise : 1'b1;
    assign wrap     = tick & (cnt_q == CNT_MAX);
    assign hit_clr  = tick & clr_on_match & (cnt_q == cmp0);

    // count register: software clear, match clear, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (sw_clr)  cnt_q <= '0;
        else if (hit_clr) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ocu_channel.sv
// Module: one compare channel.
// Detects equality on counting cycles while running. It toggles its latch on
// its own match or on a cross-channel toggle request, and sets its interrupt
// flag on its own match. A level load is honoured only while the channel is
// stopped. A flag set has priority over a flag clear in the same cycle.
module ocu_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             tick,
    input  logic             run,
    input  logic             xtoggle,
    input  logic             lvl_we,
    input  logic             lvl_d,
    input  logic             flag_clr,
    output logic             match,
    output logic             latch_q,
    output logic             flag_q
);
    logic toggle;

    assign match  = tick & run & (cnt == cmp);
    assign toggle = match | (run & xtoggle);

    // output latch: load while stopped, otherwise invert on toggle
    always_ff @(posedge clk) begin
        if (!rst_n)                latch_q <= 1'b0;
        else if (lvl_we && !run)   latch_q <= lvl_d;
        else if (toggle)           latch_q <= ~latch_q;
    end

    // interrupt flag: set on match, cleared by a written 0
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (match)    flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/ocu_pinmux.sv
// Module: per-pin selection between compare latch and general-purpose data.
// Purely combinational. Assumes NPIN matches the number of channels.
module ocu_pinmux #(
    parameter int NPIN = 2
) (
    input  logic [NPIN-1:0] sel,
    input  logic [NPIN-1:0] latch,
    input  logic [NPIN-1:0] gpio,
    output logic [NPIN-1:0] pin
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign pin[i] = sel[i] ? latch[i] : gpio[i];
    end
endmodule

// File: rtl/ocu_pair.sv
// Module: dual-channel output compare unit (top).
// Holds the register file, the shared timer, two compare channels and the
// pin multiplexer. Writes land on the clock edge and reads are combinational.
// Assumes CNT_W >= 9 so the control register fits the data bus.
module ocu_pair
    import ocu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_clk,
    input  logic [NCH-1:0]    port_sel,
    input  logic [NCH-1:0]    gpio_dout,
    output logic [NCH-1:0]    pin_out,
    output logic              irq
);
    localparam int CTRL_USED = B_LINK + 1;

    logic [NCH-1:0]   run_q, ien_q;
    logic             link_q, tmode_q, ext_sel_q, ovf_q;
    logic [CNT_W-1:0] cmp_q [NCH];
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_tick, tmr_wrap;
    logic [NCH-1:0]   ch_match, ch_latch, ch_flag, ch_xtog;
    logic             wr_ctrl, wr_tctl;
    logic             unused_wdata;

    assign wr_ctrl      = bus_wr && (bus_addr == A_CTRL);
    assign wr_tctl      = bus_wr && (bus_addr == A_TCTL);
    assign unused_wdata = &{1'b0, bus_wdata[CNT_W-1:CTRL_USED]};

    // control register: run, interrupt enable and link mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            ien_q  <= '0;
            link_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q  <= bus_wdata[B_RUN +: NCH];
            ien_q  <= bus_wdata[B_IEN +: NCH];
            link_q <= bus_wdata[B_LINK];
        end
    end

    // compare value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q[0] <= '0;
            cmp_q[1] <= '0;
        end else if (bus_wr && bus_addr == A_CMP0) begin
            cmp_q[0] <= bus_wdata;
        end else if (bus_wr && bus_addr == A_CMP1) begin
            cmp_q[1] <= bus_wdata;
        end
    end

    // timer control: clear-on-match mode and clock source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmode_q   <= 1'b0;
            ext_sel_q <= 1'b0;
        end else if (wr_tctl) begin
            tmode_q   <= bus_wdata[T_MODE];
            ext_sel_q <= bus_wdata[T_EXT];
        end
    end

    // overflow flag: set on wrap, cleared by a written 0
    always_ff @(posedge clk) begin
        if (!rst_n)                           ovf_q <= 1'b0;
        else if (tmr_wrap)                    ovf_q <= 1'b1;
        else if (wr_tctl && !bus_wdata[T_OVF]) ovf_q <= 1'b0;
    end

    ocu_timer #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_sel      (ext_sel_q),
        .ext_clk      (ext_clk),
        .sw_clr       (wr_tctl && bus_wdata[T_CLR]),
        .clr_on_match (tmode_q),
        .cmp0         (cmp_q[0]),
        .cnt_q        (tmr_cnt),
        .tick         (tmr_tick),
        .wrap         (tmr_wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == 0) begin : g_first
            assign ch_xtog[i] = 1'b0;
        end else begin : g_linked
            assign ch_xtog[i] = link_q & ch_match[0];
        end

        ocu_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (tmr_cnt),
            .cmp      (cmp_q[i]),
            .tick     (tmr_tick),
            .run      (run_q[i]),
            .xtoggle  (ch_xtog[i]),
            .lvl_we   (wr_ctrl),
            .lvl_d    (bus_wdata[B_LVL + i]),
            .flag_clr (wr_ctrl && !bus_wdata[B_FLAG + i]),
            .match    (ch_match[i]),
            .latch_q  (ch_latch[i]),
            .flag_q   (ch_flag[i])
        );
    end

    ocu_pinmux #(.NPIN(NCH)) u_pins (
        .sel   (port_sel),
        .latch (ch_latch),
        .gpio  (gpio_dout),
        .pin   (pin_out)
    );

    assign irq = |(ch_flag & ien_q);

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata[CTRL_USED-1:0] = {link_q, ch_latch, ch_flag, ien_q, run_q};
            A_CMP0: bus_rdata = cmp_q[0];
            A_CMP1: bus_rdata = cmp_q[1];
            A_TCTL: bus_rdata[3:0] = {ext_sel_q, tmode_q, 1'b0, ovf_q};
            A_TCNT: bus_rdata = tmr_cnt;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ocu_pair_chk.sv
// Module: property checker for ocu_pair, attached by bind.
// Observes the bus, the counter and per-channel state. It drives nothing.
module ocu_pair_chk
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  tmr_cnt,
    input logic              tmr_tick,
    input logic              tmode_q,
    input logic              ovf_q,
    input logic [CNT_W-1:0]  cmp0,
    input logic [NCH-1:0]    run_q,
    input logic [NCH-1:0]    ien_q,
    input logic [NCH-1:0]    ch_flag,
    input logic [NCH-1:0]    ch_latch,
    input logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wr_ctrl_c, sw_clr_c;
    assign wr_ctrl_c = bus_wr && (bus_addr == A_CTRL);
    assign sw_clr_c  = bus_wr && (bus_addr == A_TCTL) && bus_wdata[T_CLR];

    // R1: plain counting step
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && !tmode_q && !sw_clr_c && tmr_cnt != CNT_MAX)
        |=> tmr_cnt == CNT_W'($past(tmr_cnt) + 1'b1));

    // R1: wrap yields zero count and overflow flag
    p_wrap_ovf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && tmr_cnt == CNT_MAX) |=> (tmr_cnt == '0 && ovf_q));

    // R3: clear on channel 0 match
    p_clr_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && tmode_q && tmr_cnt == cmp0) |=> tmr_cnt == '0);

    // R4: a stopped channel 0 keeps its latch unless the control register is written
    p_stopped_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && !wr_ctrl_c) |=> $stable(ch_latch[0]));

    // R6: flag survives anything but a written 0
    p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag[1] && !(wr_ctrl_c && !bus_wdata[B_FLAG + 1])) |=> ch_flag[1]);

    // R7: enabled pending flag drives the interrupt line
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag[0] && ien_q[0]) |-> irq);
endmodule

bind ocu_pair ocu_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tmr_cnt   (tmr_cnt),
    .tmr_tick  (tmr_tick),
    .tmode_q   (tmode_q),
    .ovf_q     (ovf_q),
    .cmp0      (cmp_q[0]),
    .run_q     (run_q),
    .ien_q     (ien_q),
    .ch_flag   (ch_flag),
    .ch_latch  (ch_latch),
    .irq       (irq)
);

// File: tb/ocu_pair_test.sv
// Bench: ocu_pair_test. It sweeps compare periods and duty points, register
// semantics, pin selection and the external clock path. All tasks are
// entered and left just after a falling clock edge.
module ocu_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic [1:0]  port_sel = '0;
    logic [1:0]  gpio_dout = '0;
    logic [1:0]  pin_out;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ocu_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .port_sel(port_sel), .gpio_dout(gpio_dout), .pin_out(pin_out), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // cycles until pin idx changes, or limit+1 if it does not
    task automatic next_toggle(input int idx, input int limit, output int n);
        logic prev;
        prev = pin_out[idx];
        n = 0;
        while (n <= limit) begin
            @(negedge clk);
            n++;
            if (pin_out[idx] != prev) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] r, c;
        int d1, d2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd(3'd0, r); check(r == 16'h0, "R11 ctrl", r, 0);
        rd(3'd3, r); check(r == 16'h0, "R11 tctl", r, 0);
        check(irq == 1'b0, "R11 irq", irq, 0);
        port_sel = 2'b11; #1;
        check(pin_out == 2'b00, "R11 latches", pin_out, 0);

        // R1: step over several spans
        for (int k = 1; k <= 9; k += 4) begin
            rd(3'd4, c);
            repeat (k) @(negedge clk);
            rd(3'd4, r);
            check(r == 16'(c + k), "R1 step", r, 16'(c + k));
        end

        // R2 / R1: clear, wrap, overflow flag
        wr(3'd3, 16'h0002);
        rd(3'd4, r); check(r == 16'd0, "R2 sw clear", r, 0);
        rd(3'd3, r); check(r[0] == 1'b0, "R2 ovf cleared", r[0], 0);
        repeat (65535) @(negedge clk);
        rd(3'd4, r); check(r == 16'hFFFF, "R1 top count", r, 16'hFFFF);
        rd(3'd3, r); check(r[0] == 1'b0, "R1 no early ovf", r[0], 0);
        @(negedge clk);
        rd(3'd4, r); check(r == 16'd0, "R1 wrap", r, 0);
        rd(3'd3, r); check(r[0] == 1'b1, "R1 ovf set", r[0], 1);
        rd(3'd4, c);
        wr(3'd3, 16'h0001);
        rd(3'd4, r); check(r == 16'(c + 1), "R2 clr bit 0 no effect", r, 16'(c + 1));
        rd(3'd3, r); check(r[0] == 1'b1, "R2 ovf write 1 no effect", r[0], 1);
        wr(3'd3, 16'h0000);
        rd(3'd3, r); check(r[0] == 1'b0, "R2 ovf write 0", r[0], 0);

        // R3 / R4: period sweep with clear-on-match
        for (int n = 0; n <= 20; n++) begin
            wr(3'd0, 16'h0000);
            wr(3'd1, 16'(n));
            wr(3'd3, 16'h0006);
            wr(3'd0, 16'h0001);
            next_toggle(0, n + 3, d1);
            next_toggle(0, n + 3, d2);
            check(d2 == n + 1, "R3 R4 period", d2, n + 1);
            rd(3'd4, r); check(r <= 16'(n), "R3 count bounded", r, n);
        end

        // R4: stopped channel ignores matches
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd4);
        next_toggle(0, 20, d1);
        check(d1 == 21, "R4 stopped no toggle", d1, 21);
        rd(3'd0, r); check(r[4] == 1'b0, "R4 stopped no flag", r[4], 0);

        // R5: linked and unlinked duty sweep
        for (int n = 6; n <= 12; n += 3) begin
            for (int k = 1; k < n; k++) begin
                wr(3'd0, 16'h0000);
                wr(3'd1, 16'(n));
                wr(3'd2, 16'(k));
                wr(3'd3, 16'h0006);
                wr(3'd0, 16'h0103);
                next_toggle(1, n + 3, d1);
                next_toggle(1, n + 3, d1);
                next_toggle(1, n + 3, d2);
                check((d1 + d2 == n + 1) && (d1 == k + 1 || d2 == k + 1),
                      "R5 linked split", d1 * 100 + d2, (n - k) * 100 + k + 1);
            end
            wr(3'd0, 16'h0003);
            next_toggle(1, 2 * n + 4, d1);
            next_toggle(1, 2 * n + 4, d2);
            check(d2 == n + 1, "R5 unlinked period", d2, n + 1);
        end

        // R6 / R7: flags and interrupt line
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd5);
        wr(3'd3, 16'h0006);
        wr(3'd0, 16'h0005);
        repeat (10) @(negedge clk);
        rd(3'd0, r); check(r[4] == 1'b1, "R6 flag set", r[4], 1);
        check(irq == 1'b1, "R7 irq on", irq, 1);
        wr(3'd0, 16'h0014);
        wr(3'd0, 16'h0010);
        check(irq == 1'b0, "R7 irq masked", irq, 0);
        rd(3'd0, r); check(r[4] == 1'b1, "R6 flag kept by 1", r[4], 1);
        wr(3'd0, 16'h0014);
        check(irq == 1'b1, "R7 irq re-enabled", irq, 1);
        wr(3'd0, 16'h0004);
        rd(3'd0, r); check(r[4] == 1'b0, "R6 flag cleared by 0", r[4], 0);
        check(irq == 1'b0, "R7 irq off", irq, 0);
        wr(3'd0, 16'h0014);
        rd(3'd0, r); check(r[4] == 1'b0, "R6 write 1 no set", r[4], 0);

        // R8 / R9: level loads and pin selection sweep
        wr(3'd3, 16'h0002);
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        for (int lv = 0; lv < 4; lv++) begin
            wr(3'd0, 16'(lv << 6));
            rd(3'd0, r); check(r[7:6] == 2'(lv), "R8 level load", r[7:6], lv);
            for (int s = 0; s < 4; s++) begin
                for (int g = 0; g < 4; g++) begin
                    port_sel = 2'(s);
                    gpio_dout = 2'(g);
                    #1;
                    check(pin_out == ((2'(s) & 2'(lv)) | (~2'(s) & 2'(g))),
                          "R9 pin select", pin_out,
                          (s & lv) | (~s & g & 3));
                end
            end
        end
        port_sel = 2'b11;
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0003);
        wr(3'd0, 16'h00C3);
        check(pin_out == 2'b00, "R8 running ignores level", pin_out, 0);
        rd(3'd0, r); check(r[7:6] == 2'b00, "R8 running readback", r[7:6], 0);

        // R10: external clock counting
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h000A);
        rd(3'd4, r); check(r == 16'd0, "R10 cleared", r, 0);
        for (int e = 0; e < 10; e++) begin
            ext_clk = 1'b1;
            repeat (5) @(negedge clk);
            ext_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
        rd(3'd4, r); check(r == 16'd10, "R10 edge count", r, 10);
        repeat (20) @(negedge clk);
        rd(3'd4, r); check(r == 16'd10, "R10 idle hold", r, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule